// File: doc/BRIEF.md
# Programming Edge-Count Auditor

This block sits between the serial front end of a serial-access EEPROM and its program sequencer. From the moment the start bit is seen until chip select drops, it counts the serial clock rising edges. When chip select falls, it compares that count with the exact length of the decoded instruction for the current organisation. A memory-modifying instruction (single write, write-all, single erase, erase-all) goes ahead only when the two numbers agree. If an extra edge from noise has shifted the frame by one bit, or a frame was cut short, the instruction is aborted and the array is left untouched.

The front end supplies single-cycle pulses in the system clock domain: one for the start bit, one per serial clock rising edge, and one for the falling edge of chip select. It also holds the decoded two-bit opcode, the two extension bits that follow it, and the organisation select steady while a frame is in progress. The block answers with a one-cycle commit or abort pulse. Reads and the write enable/disable instructions are never judged.

Top module: `prog_edge_audit`

## Requirements
- R1: While reset is high, and in the first cycle after it, prog_commit and prog_abort are low, and no frame is open.
- R2: The start-bit pulse opens a frame with a count of 1. Each sclk_rise pulse in an open frame adds 1. An sclk_rise pulse outside a frame has no effect.
- R3: With org_wide=0 (byte organisation, 7 address bits, 8 data bits), write (op_code 01) and write-all (op_code 00, op_ext 01) expect 18 edges. Erase (op_code 11) and erase-all (op_code 00, op_ext 10) expect 10.
- R4: With org_wide=1 (word organisation, 6 address bits, 16 data bits), write and write-all expect 25 edges. Erase and erase-all expect 9.
- R5: When cs_fall closes a frame of a guarded instruction whose count equals the expected value, prog_commit is high for exactly the one cycle that follows the cs_fall pulse.
- R6: When the count of a guarded instruction differs from the expected value, whether higher or lower, prog_abort pulses in that same cycle instead.
- R7: Read (op_code 10), write enable (op_code 00, op_ext 11) and write disable (op_code 00, op_ext 00) produce neither pulse, whatever the count.
- R8: The count saturates at 63 with default parameters. A burst of 89 edges on a word write therefore aborts and does not wrap around to 25.
- R9: A cs_fall pulse with no open frame produces no pulse. An sclk_rise pulse in the same cycle as cs_fall is not counted.
- R10: A start-bit pulse inside an open frame restarts the count at 1.
- R11: prog_commit and prog_abort are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_seen | input | 1 | Pulse on the serial edge that sampled the start bit |
| sclk_rise | input | 1 | Pulse for each later serial clock rising edge |
| cs_fall | input | 1 | Pulse on the falling edge of chip select |
| op_code | input | 2 | Decoded opcode of the current frame |
| op_ext | input | 2 | Extension bits that qualify op_code 00 |
| org_wide | input | 1 | 1 selects word organisation, 0 selects byte |
| prog_commit | output | 1 | One-cycle pulse that lets the program cycle start |
| prog_abort | output | 1 | One-cycle pulse that rejects the instruction |

## Verification
The bench sends frames that are exactly right, one edge short and one edge long, for every guarded instruction in both organisations. A design with a wrong expected length would commit a misaligned frame or abort a clean one. It sends an 89-edge burst on a word write, which a wrapping counter would wrongly commit because 89 minus 64 is 25. It also drives an edge in the same cycle as cs_fall, a stray cs_fall with no frame open, and a second start bit inside a frame. Each of these catches a counter that accepts edges after deselect, judges idle time, or fails to restart. Reads, enable and disable frames must stay silent, so a decoder that guards too much is caught as well.

// File: rtl/prog_edge_audit_pkg.sv
package prog_edge_audit_pkg;

  typedef enum logic [1:0] {
    OPC_EXT   = 2'b00,
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10,
    OPC_ERASE = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    EXT_LOCK  = 2'b00,
    EXT_FILL  = 2'b01,
    EXT_WIPE  = 2'b10,
    EXT_ALLOW = 2'b11
  } ext_e;

  // frame length = start bit + opcode bits + address bits + data bits
  function automatic int frame_len(input int addr_bits, input int data_bits);
    return 1 + 2 + addr_bits + data_bits;
  endfunction

endpackage

// File: rtl/pea_edge_counter.sv
module pea_edge_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_seen,
  input  logic             sclk_rise,
  input  logic             cs_fall,
  output logic             open_q,
  output logic [CNT_W-1:0] count_q
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      count_q <= '0;
    end else if (cs_fall) begin
      open_q  <= 1'b0;
    end else if (start_seen) begin
      open_q  <= 1'b1;
      count_q <= CNT_ONE;
    end else if (sclk_rise && open_q && (count_q != CNT_TOP)) begin
      count_q <= count_q + CNT_ONE;
    end
  end

  a_r8_sat_hold: assert property (@(posedge clk) disable iff (rst)
    (open_q && count_q == CNT_TOP && sclk_rise && !start_seen && !cs_fall)
      |=> (count_q == CNT_TOP));

  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    (start_seen && !cs_fall) |=> (open_q && count_q == CNT_ONE));

  a_r9_close: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> !open_q);

  a_r2_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    (!open_q && !start_seen) |=> $stable(count_q));

endmodule

// File: rtl/pea_expect_decode.sv
module pea_expect_decode
  import prog_edge_audit_pkg::*;
#(
  parameter int ADDR_BYTE = 7,
  parameter int DATA_BYTE = 8,
  parameter int CNT_W     = 6
) (
  input  logic [1:0]       op_code,
  input  logic [1:0]       op_ext,
  input  logic             org_wide,
  output logic             guarded,
  output logic [CNT_W-1:0] expect_cnt
);

  localparam int ADDR_WORD = ADDR_BYTE - 1;
  localparam int DATA_WORD = 2 * DATA_BYTE;
  localparam logic [CNT_W-1:0] LEN_WR_B = CNT_W'(frame_len(ADDR_BYTE, DATA_BYTE));
  localparam logic [CNT_W-1:0] LEN_ER_B = CNT_W'(frame_len(ADDR_BYTE, 0));
  localparam logic [CNT_W-1:0] LEN_WR_W = CNT_W'(frame_len(ADDR_WORD, DATA_WORD));
  localparam logic [CNT_W-1:0] LEN_ER_W = CNT_W'(frame_len(ADDR_WORD, 0));

  logic has_data;
  logic has_none;

  always_comb begin
    has_data = 1'b0;
    has_none = 1'b0;
    unique case (opc_e'(op_code))
      OPC_WRITE: has_data = 1'b1;
      OPC_ERASE: has_none = 1'b1;
      OPC_READ:  ;
      OPC_EXT: begin
        if (ext_e'(op_ext) == EXT_FILL) has_data = 1'b1;
        if (ext_e'(op_ext) == EXT_WIPE) has_none = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    guarded    = has_data | has_none;
    expect_cnt = '0;
    if (has_data)      expect_cnt = org_wide ? LEN_WR_W : LEN_WR_B;
    else if (has_none) expect_cnt = org_wide ? LEN_ER_W : LEN_ER_B;
  end

  always_comb begin
    a_r7_onehot_kind: assert (!(has_data && has_none));
  end

endmodule

// File: rtl/pea_verdict.sv
module pea_verdict #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_fall,
  input  logic             open_q,
  input  logic [CNT_W-1:0] count_q,
  input  logic             guarded,
  input  logic [CNT_W-1:0] expect_cnt,
  output logic             prog_commit,
  output logic             prog_abort
);

  logic judge;
  assign judge = cs_fall && open_q && guarded;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_commit <= 1'b0;
      prog_abort  <= 1'b0;
    end else begin
      prog_commit <= judge && (count_q == expect_cnt);
      prog_abort  <= judge && (count_q != expect_cnt);
    end
  end

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(prog_commit && prog_abort));

  a_r5_after_fall: assert property (@(posedge clk) disable iff (rst)
    (prog_commit || prog_abort) |-> ($past(cs_fall) && $past(open_q)));

  a_r11_single_commit: assert property (@(posedge clk) disable iff (rst)
    prog_commit |=> !prog_commit);

  a_r11_single_abort: assert property (@(posedge clk) disable iff (rst)
    prog_abort |=> !prog_abort);

endmodule

// File: rtl/prog_edge_audit.sv
module prog_edge_audit
  import prog_edge_audit_pkg::*;
#(
  parameter int ADDR_BYTE = 7,
  parameter int DATA_BYTE = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_seen,
  input  logic       sclk_rise,
  input  logic       cs_fall,
  input  logic [1:0] op_code,
  input  logic [1:0] op_ext,
  input  logic       org_wide,
  output logic       prog_commit,
  output logic       prog_abort
);

  localparam int LEN_B = frame_len(ADDR_BYTE, DATA_BYTE);
  localparam int LEN_W = frame_len(ADDR_BYTE - 1, 2 * DATA_BYTE);
  localparam int LEN_MAX = (LEN_B > LEN_W) ? LEN_B : LEN_W;
  // one spare bit of headroom above the longest legal frame
  localparam int CNT_W = $clog2(LEN_MAX + 1) + 1;

  logic             open_q;
  logic [CNT_W-1:0] count_q;
  logic             guarded;
  logic [CNT_W-1:0] expect_cnt;

  pea_edge_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .start_seen(start_seen), .sclk_rise(sclk_rise),
    .cs_fall(cs_fall), .open_q(open_q), .count_q(count_q)
  );

  pea_expect_decode #(.ADDR_BYTE(ADDR_BYTE), .DATA_BYTE(DATA_BYTE), .CNT_W(CNT_W)) u_dec (
    .op_code(op_code), .op_ext(op_ext), .org_wide(org_wide),
    .guarded(guarded), .expect_cnt(expect_cnt)
  );

  pea_verdict #(.CNT_W(CNT_W)) u_judge (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .open_q(open_q), .count_q(count_q),
    .guarded(guarded), .expect_cnt(expect_cnt),
    .prog_commit(prog_commit), .prog_abort(prog_abort)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!prog_commit && !prog_abort));

endmodule

// File: tb/prog_edge_audit_tb.sv
module prog_edge_audit_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_seen = 1'b0, sclk_rise = 1'b0, cs_fall = 1'b0;
  logic [1:0] op_code = 2'b10, op_ext = 2'b00;
  logic org_wide = 1'b0;
  logic prog_commit, prog_abort;

  int checks = 0, fails = 0;
  int seen_c = 0, seen_a = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  prog_edge_audit u_dut (
    .clk(clk), .rst(rst), .start_seen(start_seen), .sclk_rise(sclk_rise),
    .cs_fall(cs_fall), .op_code(op_code), .op_ext(op_ext), .org_wide(org_wide),
    .prog_commit(prog_commit), .prog_abort(prog_abort)
  );

  // behavioural reference
  int  m_cnt = 0;
  bit  m_open = 0;
  bit  exp_c = 0, exp_a = 0;

  function automatic int want_len(logic [1:0] oc, logic [1:0] ex, logic w);
    bit data, none;
    data = (oc == 2'b01) || (oc == 2'b00 && ex == 2'b01);
    none = (oc == 2'b11) || (oc == 2'b00 && ex == 2'b10);
    if (data) return w ? 25 : 18;
    if (none) return w ? 9 : 10;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_cnt = 0; exp_c = 0; exp_a = 0;
    end else begin
      int lenx;
      exp_c = 0; exp_a = 0;
      if (cs_fall) begin
        if (m_open) begin
          lenx = want_len(op_code, op_ext, org_wide);
          if (lenx > 0) begin
            if (m_cnt == lenx) exp_c = 1; else exp_a = 1;
          end
        end
        m_open = 0;
      end else if (start_seen) begin
        m_open = 1; m_cnt = 1;
      end else if (sclk_rise && m_open && m_cnt < 63) begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (prog_commit !== exp_c || prog_abort !== exp_a) begin
      fails++;
      $display("FAIL %s: commit/abort = %b%b, expected %b%b at %0t",
               cur_req, prog_commit, prog_abort, exp_c, exp_a, $time);
    end
    if (prog_commit) seen_c++;
    if (prog_abort)  seen_a++;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 none, 1 commit, 2 abort
  task automatic frame(logic [1:0] oc, logic [1:0] ex, logic w, int edges,
                       bit edge_at_fall, int kind, string tag);
    int c0, a0, gc, ga;
    cur_req = tag;
    op_code = oc; op_ext = ex; org_wide = w;
    c0 = seen_c; a0 = seen_a;
    @(negedge clk); start_seen = 1'b1;
    @(negedge clk); start_seen = 1'b0;
    for (int i = 1; i < edges; i++) begin
      sclk_rise = 1'b1; @(negedge clk);
      sclk_rise = 1'b0; @(negedge clk);
    end
    cs_fall = 1'b1; sclk_rise = edge_at_fall;
    @(negedge clk); cs_fall = 1'b0; sclk_rise = 1'b0;
    idle(3);
    gc = seen_c - c0; ga = seen_a - a0;
    checks++;
    if (gc != (kind == 1) || ga != (kind == 2)) begin
      fails++;
      $display("FAIL %s: commits=%0d aborts=%0d, expected kind %0d", tag, gc, ga, kind);
    end
  endtask

  initial begin
    int c0, a0;
    idle(3);
    checks++;
    if (prog_commit !== 1'b0 || prog_abort !== 1'b0) begin
      fails++;
      $display("FAIL R1: outputs %b%b, expected 00", prog_commit, prog_abort);
    end
    rst = 1'b0;
    idle(2);
    // R3 byte organisation
    frame(2'b01, 2'b00, 1'b0, 18, 0, 1, "R3 R5 byte write");
    frame(2'b00, 2'b01, 1'b0, 18, 0, 1, "R3 byte write-all");
    frame(2'b11, 2'b00, 1'b0, 10, 0, 1, "R3 byte erase");
    frame(2'b00, 2'b10, 1'b0, 10, 0, 1, "R3 byte erase-all");
    frame(2'b01, 2'b00, 1'b0, 17, 0, 2, "R6 byte write short");
    frame(2'b01, 2'b00, 1'b0, 19, 0, 2, "R6 byte write long");
    // R4 word organisation
    frame(2'b01, 2'b00, 1'b1, 25, 0, 1, "R4 word write");
    frame(2'b00, 2'b01, 1'b1, 25, 0, 1, "R4 word write-all");
    frame(2'b11, 2'b00, 1'b1, 9, 0, 1, "R4 word erase");
    frame(2'b00, 2'b10, 1'b1, 9, 0, 1, "R4 word erase-all");
    frame(2'b11, 2'b00, 1'b1, 10, 0, 2, "R6 word erase long");
    frame(2'b00, 2'b10, 1'b1, 8, 0, 2, "R6 word erase-all short");
    // R7 unguarded
    frame(2'b10, 2'b00, 1'b0, 18, 0, 0, "R7 read");
    frame(2'b00, 2'b11, 1'b0, 10, 0, 0, "R7 enable");
    frame(2'b00, 2'b00, 1'b1, 9, 0, 0, "R7 disable");
    // R8 saturation: 89 edges would wrap to 25 in six bits
    frame(2'b01, 2'b00, 1'b1, 89, 0, 2, "R8 saturation");
    frame(2'b11, 2'b00, 1'b0, 70, 0, 2, "R8 long erase");
    // R9 edge in cs_fall cycle ignored
    frame(2'b11, 2'b00, 1'b0, 10, 1, 1, "R9 edge at fall");
    // R9 stray cs_fall with no open frame
    cur_req = "R9 stray fall";
    c0 = seen_c; a0 = seen_a;
    op_code = 2'b11; org_wide = 1'b0;
    cs_fall = 1'b1; @(negedge clk); cs_fall = 1'b0;
    repeat (10) begin sclk_rise = 1'b1; @(negedge clk); sclk_rise = 1'b0; @(negedge clk); end
    cs_fall = 1'b1; @(negedge clk); cs_fall = 1'b0;
    idle(3);
    checks++;
    if (seen_c != c0 || seen_a != a0) begin
      fails++;
      $display("FAIL R9: pulses %0d/%0d, expected 0/0", seen_c - c0, seen_a - a0);
    end
    // R10 restart: 5 edges, new start, then 10 edges total -> byte erase commit
    cur_req = "R10 restart";
    c0 = seen_c;
    start_seen = 1'b1; @(negedge clk); start_seen = 1'b0;
    repeat (4) begin sclk_rise = 1'b1; @(negedge clk); sclk_rise = 1'b0; @(negedge clk); end
    start_seen = 1'b1; @(negedge clk); start_seen = 1'b0;
    repeat (9) begin sclk_rise = 1'b1; @(negedge clk); sclk_rise = 1'b0; @(negedge clk); end
    cs_fall = 1'b1; @(negedge clk); cs_fall = 1'b0;
    idle(3);
    checks++;
    if (seen_c != c0 + 1) begin
      fails++;
      $display("FAIL R10: commits %0d, expected 1", seen_c - c0);
    end
    // R2 edges before any start do not count; R11 checked every cycle
    frame(2'b11, 2'b00, 1'b1, 9, 0, 1, "R2 R11 clean frame");
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule